// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

One channel of a general-purpose timer. An up-counter advances on count ticks taken either from a bus-clock prescaler or from rising edges on a primary input pin. The pin, and a secondary trigger pin, pass through a two-flop synchronizer before any edge is detected. The counter is compared with one of two compare registers, chosen by a control bit, so software can rewrite the idle register for the next period. On a match, the next tick loads the counter from a load register instead of incrementing it, and a sticky compare flag is set. The flag can raise an interrupt.

The count mode selects free edge counting, or triggered counting that waits for a rising edge on the secondary input and then runs until the next compare reload. The output mode drives the output flag pin. It can toggle on each reload, emit a gated copy of the count source while the counter is active, or stay low. A match, once reached, is remembered until the next tick. A late compare rewrite therefore cannot turn a reload into an increment, even when ticks are much slower than the bus clock. In triggered gated mode, no output pulse appears before the trigger edge.

Software reaches the channel through a single-cycle register port. A write takes effect at the next clock edge, and read data is combinational from the address.

Top module: `tmr_channel`

## Requirements
- R1: After reset, every register reads 0, the counter is 0, `out_flag` and `cmp_irq` are low, and the status register reads 0.
- R2: Register addresses are: 0 control, 1 load, 2 compare 0, 3 compare 1, 4 counter (a write sets the counter), 5 status, and 6 prescaler divisor. Control, load, compare and divisor registers read back what was written. Control fields are: bits [2:0] count mode, bits [5:3] output mode, bit 6 source (1 = primary pin, 0 = prescaler), bit 7 compare select (0 = compare 0, 1 = compare 1), and bit 8 interrupt enable. Status fields are: bit 0 compare flag, bit 1 output flag, and bit 2 counter active.
- R3: In count mode 3'b001 the counter increments by one on every tick. A tick is one rising edge of the synchronized primary pin, or one prescaler pulse every divisor+1 bus clocks.
- R4: On a tick where the counter equals the selected compare register, the counter loads the load value instead of incrementing, and the compare flag is set. Writing 1 to status bit 0 clears the flag. A simultaneous set wins over the clear.
- R5: If the counter and the selected compare value were equal on any cycle since the last tick, the next tick reloads, even if the compare register was rewritten in between.
- R6: Output mode 3'b011 inverts `out_flag` on every reload. With load 0 and compare 0 in count mode 3'b001, `out_flag` is the primary edge train divided by two.
- R7: Count mode 3'b110 ignores ticks until a rising edge on the synchronized secondary input. The channel then counts ticks, and the reload tick ends the active period. Leaving the mode cancels a pending or running trigger.
- R8: Output mode 3'b111 drives `out_flag` high while the counter is active and the delayed source level is high. In count mode 3'b110 it stays low before the trigger edge, and it emits one pulse per incrementing tick and none for the reload tick.
- R9: `cmp_irq` is high exactly when the compare flag is set and control bit 8 is 1.
- R10: Count mode 3'b000, and any other unlisted code, holds the counter. Output modes other than 3'b011 and 3'b111 drive `out_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| pri_in | input | 1 | Primary count input, asynchronous |
| sec_in | input | 1 | Secondary trigger input, asynchronous |
| out_flag | output | 1 | Output flag pin |
| cmp_irq | output | 1 | Compare interrupt |

## Verification
Primary-edge counting is driven both with directed sequences and with randomly drawn load values, compare values and pulse counts. A bench model predicts the counter, flag and toggled output. This separates plain incrementing from reload, and it separates the compare-0 path from the compare-1 path. A compare rewrite placed between a match and the following tick separates a remembered match from a live-only comparison. Pulses sent before and after a secondary edge in triggered gated mode separate suppression before the trigger, the output pulse count and the stop at reload. The prescaler source is checked against an expected tick-count window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [2:0] CM_STOP = 3'b000;
    localparam logic [2:0] CM_EDGE = 3'b001;
    localparam logic [2:0] CM_TRIG = 3'b110;

    localparam logic [2:0] OM_LOW    = 3'b000;
    localparam logic [2:0] OM_TOGGLE = 3'b011;
    localparam logic [2:0] OM_GATED  = 3'b111;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_LOAD  = 3'd1,
        RA_CMP0  = 3'd2,
        RA_CMP1  = 3'd3,
        RA_COUNT = 3'd4,
        RA_STAT  = 3'd5,
        RA_PSC   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       cmp_sel;
        logic       src_pin;
        logic [2:0] omode;
        logic [2:0] cmode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic mode_is_edge(input logic [2:0] cm);
        return cm == CM_EDGE;
    endfunction

    function automatic logic mode_is_trig(input logic [2:0] cm);
        return cm == CM_TRIG;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] lvl
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic s1, s2, s3;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                    s3 <= 1'b0;
                end else begin
                    s1 <= din[i];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign rise[i] = s2 & ~s3;
            assign lvl[i]  = s3;
        end
    endgenerate
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] div,
    output logic          tick,
    output logic          sq
);
    logic [PW-1:0] pcnt;

    assign tick = (pcnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            sq   <= 1'b0;
        end else begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
            if (tick) sq <= ~sq;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [W-1:0]  wr_data,
    output ctrl_t         ctrl,
    output logic [W-1:0]  load_val,
    output logic [W-1:0]  cmp0,
    output logic [W-1:0]  cmp1,
    output logic [PW-1:0] psc_div,
    output logic          cnt_wr,
    output logic          flag_clr
);
    assign cnt_wr   = wr_en && (addr == RA_COUNT);
    assign flag_clr = wr_en && (addr == RA_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            load_val <= '0;
            cmp0     <= '0;
            cmp1     <= '0;
            psc_div  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL: ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                RA_LOAD: load_val <= wr_data;
                RA_CMP0: cmp0     <= wr_data;
                RA_CMP1: cmp1     <= wr_data;
                RA_PSC:  psc_div  <= wr_data[PW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    input  logic         src_tick,
    input  logic         src_lvl,
    input  logic         sec_rise,
    output logic [W-1:0] count,
    output logic         cmp_flag,
    output logic         out_flag,
    output logic         active,
    output logic         go,
    output logic         reload_evt
);
    logic [W-1:0] cmp_act;
    logic         match_now, armed_q, run_q, tog_q;
    logic         in_edge, in_trig;

    assign cmp_act    = ctrl.cmp_sel ? cmp1 : cmp0;
    assign match_now  = (count == cmp_act);
    assign in_edge    = mode_is_edge(ctrl.cmode);
    assign in_trig    = mode_is_trig(ctrl.cmode);
    assign active     = in_edge | (in_trig & run_q);
    assign go         = src_tick & active & ~cnt_wr;
    assign reload_evt = go & (armed_q | match_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            armed_q  <= 1'b0;
            cmp_flag <= 1'b0;
            run_q    <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            if (cnt_wr)          count <= wr_data;
            else if (reload_evt) count <= load_val;
            else if (go)         count <= count + 1'b1;

            if (cnt_wr || go) armed_q <= 1'b0;
            else              armed_q <= armed_q | match_now;

            if (reload_evt)    cmp_flag <= 1'b1;
            else if (flag_clr) cmp_flag <= 1'b0;

            if (!in_trig)        run_q <= 1'b0;
            else if (reload_evt) run_q <= 1'b0;
            else if (sec_rise)   run_q <= 1'b1;

            if (reload_evt && ctrl.omode == OM_TOGGLE) tog_q <= ~tog_q;
        end
    end

    always_comb begin
        case (ctrl.omode)
            OM_TOGGLE: out_flag = tog_q;
            OM_GATED:  out_flag = active & src_lvl;
            default:   out_flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         pri_in,
    input  logic         sec_in,
    output logic         out_flag,
    output logic         cmp_irq
);
    ctrl_t         ctrl;
    logic [W-1:0]  load_val, cmp0, cmp1, count;
    logic [PW-1:0] psc_div;
    logic          cnt_wr, flag_clr;
    logic [1:0]    pin_rise, pin_lvl;
    logic          psc_tick, psc_sq;
    logic          src_tick, src_lvl;
    logic          cmp_flag, active, go, reload_evt;

    tmr_regs #(.W(W), .PW(PW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .ctrl(ctrl), .load_val(load_val), .cmp0(cmp0), .cmp1(cmp1),
        .psc_div(psc_div), .cnt_wr(cnt_wr), .flag_clr(flag_clr)
    );

    tmr_edge_sync #(.N(2)) u_sync (
        .clk(clk), .rst(rst), .din({sec_in, pri_in}),
        .rise(pin_rise), .lvl(pin_lvl)
    );

    tmr_prescaler #(.PW(PW)) u_psc (
        .clk(clk), .rst(rst), .div(psc_div), .tick(psc_tick), .sq(psc_sq)
    );

    assign src_tick = ctrl.src_pin ? pin_rise[0] : psc_tick;
    assign src_lvl  = ctrl.src_pin ? pin_lvl[0]  : psc_sq;

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl), .load_val(load_val),
        .cmp0(cmp0), .cmp1(cmp1), .cnt_wr(cnt_wr), .wr_data(wr_data),
        .flag_clr(flag_clr), .src_tick(src_tick), .src_lvl(src_lvl),
        .sec_rise(pin_rise[1]), .count(count), .cmp_flag(cmp_flag),
        .out_flag(out_flag), .active(active), .go(go), .reload_evt(reload_evt)
    );

    assign cmp_irq = cmp_flag & ctrl.irq_en;

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
            RA_LOAD:  rd_data = load_val;
            RA_CMP0:  rd_data = cmp0;
            RA_CMP1:  rd_data = cmp1;
            RA_COUNT: rd_data = count;
            RA_STAT:  rd_data[2:0] = {active, out_flag, cmp_flag};
            RA_PSC:   rd_data[PW-1:0] = psc_div;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input ctrl_t        ctrl,
    input logic [W-1:0] count,
    input logic [W-1:0] load_val,
    input logic         go,
    input logic         reload_evt,
    input logic         cmp_flag,
    input logic         out_flag,
    input logic         cmp_irq,
    input logic         active,
    input logic [1:0]   pin_rise,
    input logic [1:0]   pin_lvl
);
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (go && !reload_evt) |=> count == W'($past(count) + 1'b1));

    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
        reload_evt |=> count == $past(load_val));

    assert_flag_R4: assert property (@(posedge clk) disable iff (rst)
        reload_evt |=> cmp_flag);

    assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (reload_evt && ctrl.omode == OM_TOGGLE && !wr_en) |=> out_flag != $past(out_flag));

    assert_trig_start_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmode == CM_TRIG && pin_rise[1] && !reload_evt && !wr_en) |=> active);

    assert_sync_R7: assert property (@(posedge clk) disable iff (rst)
        pin_rise[1] |=> pin_lvl[1]);

    assert_no_early_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmode == CM_TRIG && ctrl.omode == OM_GATED && !active) |-> !out_flag);

    assert_gate_src_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.omode == OM_GATED && ctrl.src_pin && !pin_lvl[0]) |-> !out_flag);

    assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
        cmp_irq |-> cmp_flag);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmode == CM_STOP && !wr_en) |=> $stable(count));
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ctrl(ctrl), .count(count),
    .load_val(load_val), .go(go), .reload_evt(reload_evt), .cmp_flag(cmp_flag),
    .out_flag(out_flag), .cmp_irq(cmp_irq), .active(active),
    .pin_rise(pin_rise), .pin_lvl(pin_lvl)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        pri_in = 1'b0;
    logic        sec_in = 1'b0;
    logic        out_flag, cmp_irq;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    logic prev_out = 1'b0;
    logic mon_en = 1'b0;

    always #4 clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pri_in(pri_in), .sec_in(sec_in),
        .out_flag(out_flag), .cmp_irq(cmp_irq)
    );

    always @(negedge clk) begin
        if (mon_en && out_flag && !prev_out) rises <= rises + 1;
        prev_out <= out_flag;
    end

    function automatic logic [15:0] mk_ctrl(input logic irq, input logic sel,
                                            input logic pin, input logic [2:0] om,
                                            input logic [2:0] cm);
        return {7'd0, irq, sel, pin, om, cm};
    endfunction

    function automatic logic [15:0] model_step(input logic [15:0] c,
                                               input logic [15:0] ld,
                                               input logic [15:0] cp);
        return (c == cp) ? ld : c + 16'd1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse_pri();
        @(negedge clk); pri_in = 1'b1;
        repeat (4) @(negedge clk);
        pri_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_sec();
        @(negedge clk); sec_in = 1'b1;
        repeat (4) @(negedge clk);
        sec_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] ld, cp, ec;
        logic        ef, eo;
        int          n;
        void'($urandom(32'h0005_eed5));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 out_flag", out_flag, 0);
        check("R1 cmp_irq", cmp_irq, 0);
        rd(3'd0, d); check("R1 ctrl", d, 0);
        rd(3'd4, d); check("R1 count", d, 0);
        rd(3'd5, d); check("R1 status", d, 0);

        // R2 readback
        wr(3'd1, 16'h1234); rd(3'd1, d); check("R2 load", d, 16'h1234);
        wr(3'd3, 16'hbeef); rd(3'd3, d); check("R2 cmp1", d, 16'hbeef);
        wr(3'd6, 16'h0005); rd(3'd6, d); check("R2 psc", d, 16'h0005);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b000, 3'b001));
        rd(3'd0, d); check("R2 ctrl", d, 16'h0041);

        // R3 pin edge counting
        wr(3'd2, 16'hffff); wr(3'd4, 16'd0);
        for (int i = 0; i < 5; i++) pulse_pri();
        rd(3'd4, d); check("R3 pin count", d, 5);

        // R3 prescaler source, divisor 3 -> one tick every 4 clocks
        wr(3'd6, 16'd3);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'b000, 3'b001));
        wr(3'd4, 16'd0);
        repeat (40) @(negedge clk);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'b000, 3'b000));
        rd(3'd4, d); check("R3 prescaler window", (d >= 9 && d <= 11), 1);

        // R4 reload on compare 0
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b000, 3'b001));
        wr(3'd1, 16'd2); wr(3'd2, 16'd4); wr(3'd4, 16'd0);
        for (int i = 0; i < 5; i++) pulse_pri();
        rd(3'd4, d); check("R4 reload count", d, 2);
        rd(3'd5, d); check("R4 flag set", d[0], 1);
        check("R9 irq masked", cmp_irq, 0);
        wr(3'd0, mk_ctrl(1'b1, 1'b0, 1'b1, 3'b000, 3'b001));
        check("R9 irq enabled", cmp_irq, 1);
        wr(3'd5, 16'd1);
        rd(3'd5, d); check("R4 flag clear", d[0], 0);
        check("R9 irq after clear", cmp_irq, 0);

        // R4 compare 1 selected
        wr(3'd3, 16'd1);
        wr(3'd0, mk_ctrl(1'b0, 1'b1, 1'b1, 3'b000, 3'b001));
        wr(3'd4, 16'd0);
        pulse_pri(); pulse_pri();
        rd(3'd4, d); check("R4 cmp1 reload", d, 2);

        // R5 compare rewritten after match, before tick
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b000, 3'b001));
        wr(3'd5, 16'd1);
        wr(3'd1, 16'd7); wr(3'd2, 16'd3); wr(3'd4, 16'd3);
        repeat (3) @(negedge clk);
        wr(3'd2, 16'd100);
        pulse_pri();
        rd(3'd4, d); check("R5 remembered match", d, 7);
        rd(3'd5, d); check("R5 flag", d[0], 1);

        // R6 divide by two
        wr(3'd1, 16'd0); wr(3'd2, 16'd0); wr(3'd4, 16'd0);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b011, 3'b001));
        eo = out_flag;
        for (int i = 0; i < 4; i++) begin
            pulse_pri();
            eo = ~eo;
            check("R6 toggle per edge", out_flag, eo);
        end

        // R7/R8 triggered gated: load 5, compare 3, start 0
        wr(3'd1, 16'd5); wr(3'd2, 16'd3); wr(3'd4, 16'd0);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b111, 3'b110));
        @(negedge clk); rises = 0; mon_en = 1'b1;
        for (int i = 0; i < 3; i++) pulse_pri();
        check("R8 no pulse before trigger", rises, 0);
        rd(3'd4, d); check("R7 idle count", d, 0);
        rd(3'd5, d); check("R7 idle inactive", d[2], 0);
        pulse_sec();
        rd(3'd5, d); check("R7 active after trigger", d[2], 1);
        for (int i = 0; i < 5; i++) pulse_pri();
        mon_en = 1'b0;
        check("R8 pulse count", rises, 3);
        rd(3'd4, d); check("R7 stop after reload", d, 5);
        rd(3'd5, d); check("R7 inactive after reload", d[2], 0);

        // R10 stop mode, low output mode
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b000, 3'b000));
        wr(3'd4, 16'd9);
        for (int i = 0; i < 3; i++) pulse_pri();
        rd(3'd4, d); check("R10 hold", d, 9);
        check("R10 out low", out_flag, 0);
        wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b000, 3'b101));
        pulse_pri();
        rd(3'd4, d); check("R10 unlisted mode hold", d, 9);

        // Random edge-count / toggle runs against a model (R3 R4 R6)
        for (int it = 0; it < 12; it++) begin
            ld = 16'($urandom_range(0, 5));
            cp = ld + 16'($urandom_range(0, 6));
            n  = $urandom_range(1, 14);
            wr(3'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'b011, 3'b001));
            wr(3'd1, ld); wr(3'd2, cp); wr(3'd5, 16'd1); wr(3'd4, ld);
            ec = ld; ef = 1'b0; eo = out_flag;
            for (int k = 0; k < n; k++) begin
                if (ec == cp) begin ef = 1'b1; eo = ~eo; end
                ec = model_step(ec, ld, cp);
                pulse_pri();
            end
            rd(3'd4, d); check("R3 random count", d, ec);
            rd(3'd5, d); check("R4 random flag", d[0], ef);
            check("R6 random out", out_flag, eo);
        end

        finish_run();
    end
endmodule